// File: doc/BRIEF.md
# Spare-Element Index Remapper

This block makes a physical array that holds a few extra elements per group look like a flawless array of a fixed, smaller size. The physical array is split into groups. Each group has `LPG` elements visible to the user plus `SPARES` extra elements. A fault mask is written once for each group through a plain configuration port, after the array has been tested at boot. The writer then pulses a completion signal. From that point the map is frozen, because defects are persistent.

Once the map is frozen, each logical index translates combinationally to a physical index. Inside its group, logical element k lands on the k-th fault-free physical element, counted upward from the lowest position. A group with no faults therefore maps straight through and never touches its spares. A group with one fault shifts every element at or above the fault up by one.

The same translation drives a read-data path. A beat carries one word per physical lane. The block reorders it so that one word appears per logical lane. A group whose mask shows more faults than it has spares is flagged as unrepairable, and that flag stays set until reset. The whole array counts as yielded only when the map is frozen and no group is flagged.

The data path is a combinational valid/ready stage with no storage. Its rules are as follows:
- `out_valid` follows `in_valid`.
- `in_ready` follows `out_ready`.
- Both are held low until the map is frozen.

A beat transfers on a cycle where `in_valid` and `in_ready` are both high. Back-pressure from downstream reaches upstream in the same cycle.

Top module: `spare_remap`

## Requirements
- R1: While reset is asserted, and directly after it, `map_ready`, `yielded`, `bad_groups`, `out_valid` and `in_ready` are all 0, and every fault mask is all-zero.
- R2: A mask write takes effect only when `cfg_en` and `cfg_we` are both 1 at a clock edge. Bit p of `cfg_mask` set means physical position p of group `cfg_grp` is faulty. A write with `cfg_en` at 0 leaves the map unchanged.
- R3: `map_ready` becomes 1 on the clock edge after `cfg_done` is sampled high, and then stays 1 until reset.
- R4: In a group with an all-zero mask, logical local index k maps to physical local index k, so the spare positions `LPG`..`LPG+SPARES-1` are never selected.
- R5: In a group with exactly one faulty position f, local index k maps to k + (k >= f ? 1 : 0).
- R6: In general, local index k maps to the k-th zero bit of the group mask, counted from bit 0. The global physical index is group*(LPG+SPARES) + local, where logical index i belongs to group i/LPG at local k = i%LPG.
- R7: A write whose mask has more set bits than `SPARES` sets bit g of `bad_groups` for the target group. The bit stays set until reset, even if the group is rewritten with a repairable mask.
- R8: `yielded` is 1 exactly when `map_ready` is 1 and `bad_groups` is zero.
- R9: `look_valid` is 1 exactly when `map_ready` is 1 and the group of `look_idx` is not flagged. `look_phys` gives the translation of `look_idx`.
- R10: When `out_valid` is 1, logical lane l of `out_data` (bits l*W +: W) equals physical lane phys(l) of `in_data`.
- R11: `out_valid` = `in_valid` & `map_ready`, and `in_ready` = `out_ready` & `map_ready`, both combinational.
- R12: Once `map_ready` is 1, mask writes are ignored even when `cfg_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration enable; qualifies mask writes |
| cfg_we | input | 1 | Mask write strobe |
| cfg_grp | input | GSEL_W | Group addressed by the write |
| cfg_mask | input | LPG+SPARES | Fault mask, one bit per physical position |
| cfg_done | input | 1 | Freezes the map |
| map_ready | output | 1 | Map frozen; translations are valid |
| yielded | output | 1 | Frozen and every group is repairable |
| bad_groups | output | GROUPS | Sticky unrepairable flag per group |
| look_idx | input | LW | Logical index to translate |
| look_phys | output | PW | Physical index for `look_idx` |
| look_valid | output | 1 | `look_phys` is usable |
| in_valid | input | 1 | Physical read beat valid |
| in_ready | output | 1 | Beat accepted |
| in_data | input | NPHYS*W | One word per physical lane |
| out_valid | output | 1 | Logical beat valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | NLOG*W | One word per logical lane |

## Verification
The hardest cases to reach are the ones that depend on history. One is a write that arrives after the map is frozen. Another is an unrepairable group that is later rewritten with a clean mask, and whose flag must stay set. The stimulus reaches them in two configuration sessions separated by a reset. In the first session, one group is written with `cfg_en` low, and another group is rewritten after `cfg_done`. In the second session, a group receives too many faults and is then cleared before the map is frozen. A behavioural model follows every write and is compared against all outputs on every cycle, while index sweeps and random beats under toggling back-pressure run alongside.

// File: rtl/spare_remap_pkg.sv
package spare_remap_pkg;

  // Number of set bits in a mask of up to 64 positions.
  function automatic int unsigned pop64(logic [63:0] m);
    int unsigned n;
    n = 0;
    for (int p = 0; p < 64; p++) n += int'(m[p]);
    return n;
  endfunction

  // Position of the k-th clear bit among the low 'width' bits; k itself if absent.
  function automatic int unsigned kth_clear(logic [63:0] m, int unsigned width,
                                            int unsigned k);
    int unsigned seen;
    int unsigned pos;
    logic        hit;
    seen = 0;
    pos  = k;
    hit  = 1'b0;
    for (int p = 0; p < 64; p++) begin
      if (p < int'(width) && !m[p] && !hit) begin
        if (seen == k) begin
          pos = p;
          hit = 1'b1;
        end
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/remap_fault_table.sv
module remap_fault_table
  import spare_remap_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int GP     = 6,
  parameter int SPARES = 2,
  localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [GSEL_W-1:0]    cfg_grp,
  input  logic [GP-1:0]        cfg_mask,
  input  logic                 cfg_done,
  output logic [GROUPS*GP-1:0] fault_flat,
  output logic [GROUPS-1:0]    bad_q,
  output logic                 frozen_q
);

  logic wr_ok;
  logic too_many;

  assign wr_ok    = cfg_en && cfg_we && !frozen_q;
  assign too_many = pop64(64'(cfg_mask)) > SPARES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
    end else if (cfg_done) begin
      frozen_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = wr_ok && (int'(cfg_grp) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fault_flat[g*GP +: GP] <= '0;
        bad_q[g]               <= 1'b0;
      end else if (hit) begin
        fault_flat[g*GP +: GP] <= cfg_mask;
        if (too_many) bad_q[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/remap_group_xlate.sv
module remap_group_xlate
  import spare_remap_pkg::*;
#(
  parameter int LPG = 4,
  parameter int GP  = 6,
  localparam int LSW = (GP > 1) ? $clog2(GP) : 1
) (
  input  logic [GP-1:0]  mask,
  output logic [LSW-1:0] sel [LPG]
);

  for (genvar k = 0; k < LPG; k++) begin : g_lane
    assign sel[k] = LSW'(kth_clear(64'(mask), GP, k));
  end

endmodule

// File: rtl/remap_lane_mux.sv
module remap_lane_mux #(
  parameter int NLOG  = 16,
  parameter int NPHYS = 24,
  parameter int W     = 8,
  parameter int PW    = 5
) (
  input  logic [NPHYS*W-1:0] in_data,
  input  logic [PW-1:0]      phys_of [NLOG],
  output logic [NLOG*W-1:0]  out_data
);

  for (genvar l = 0; l < NLOG; l++) begin : g_out
    always_comb begin
      out_data[l*W +: W] = '0;
      if (int'(phys_of[l]) < NPHYS) out_data[l*W +: W] = in_data[int'(phys_of[l])*W +: W];
    end
  end

endmodule

// File: rtl/spare_remap.sv
module spare_remap #(
  parameter int GROUPS = 4,
  parameter int LPG    = 4,
  parameter int SPARES = 2,
  parameter int W      = 8,
  localparam int GP     = LPG + SPARES,
  localparam int NLOG   = GROUPS * LPG,
  localparam int NPHYS  = GROUPS * GP,
  localparam int LW     = (NLOG > 1) ? $clog2(NLOG) : 1,
  localparam int PW     = (NPHYS > 1) ? $clog2(NPHYS) : 1,
  localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int LSW    = (GP > 1) ? $clog2(GP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_we,
  input  logic [GSEL_W-1:0]  cfg_grp,
  input  logic [GP-1:0]      cfg_mask,
  input  logic               cfg_done,
  output logic               map_ready,
  output logic               yielded,
  output logic [GROUPS-1:0]  bad_groups,
  input  logic [LW-1:0]      look_idx,
  output logic [PW-1:0]      look_phys,
  output logic               look_valid,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NPHYS*W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NLOG*W-1:0]  out_data
);

  logic [GROUPS*GP-1:0] fault_flat;
  logic [PW-1:0]        phys_tab [NLOG];

  remap_fault_table #(.GROUPS(GROUPS), .GP(GP), .SPARES(SPARES)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_grp   (cfg_grp),
    .cfg_mask  (cfg_mask),
    .cfg_done  (cfg_done),
    .fault_flat(fault_flat),
    .bad_q     (bad_groups),
    .frozen_q  (map_ready)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_xl
    logic [LSW-1:0] sel [LPG];

    remap_group_xlate #(.LPG(LPG), .GP(GP)) u_xl (
      .mask(fault_flat[g*GP +: GP]),
      .sel (sel)
    );

    for (genvar k = 0; k < LPG; k++) begin : g_k
      assign phys_tab[g*LPG + k] = PW'(g * GP) + PW'(sel[k]);
    end
  end

  remap_lane_mux #(.NLOG(NLOG), .NPHYS(NPHYS), .W(W), .PW(PW)) u_mux (
    .in_data (in_data),
    .phys_of (phys_tab),
    .out_data(out_data)
  );

  logic idx_in_range;
  int   look_grp;

  assign idx_in_range = int'(look_idx) < NLOG;
  assign look_grp     = int'(look_idx) / LPG;

  always_comb begin
    look_phys  = '0;
    look_valid = 1'b0;
    if (idx_in_range) begin
      look_phys  = phys_tab[look_idx];
      look_valid = map_ready && !bad_groups[look_grp];
    end
  end

  assign yielded   = map_ready && (bad_groups == '0);
  assign out_valid = in_valid && map_ready;
  assign in_ready  = out_ready && map_ready;

endmodule

// File: rtl/spare_remap_chk.sv
module spare_remap_chk #(
  parameter int GROUPS = 4,
  parameter int GP     = 6,
  parameter int NPHYS  = 24,
  parameter int PW     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_done,
  input logic                 map_ready,
  input logic                 yielded,
  input logic [GROUPS-1:0]    bad_groups,
  input logic [GROUPS*GP-1:0] fault_flat,
  input logic                 look_valid,
  input logic [PW-1:0]        look_phys,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready
);

  a_r3_done_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> map_ready);

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    map_ready |=> map_ready);

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bad_groups & $past(bad_groups)) == $past(bad_groups)));

  a_r8_yield_needs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    yielded |-> (map_ready && bad_groups == '0));

  a_r9_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |-> map_ready);

  a_r6_phys_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |-> (int'(look_phys) < NPHYS));

  a_r11_no_flow_unfrozen: assert property (@(posedge clk) disable iff (!rst_n)
    !map_ready |-> (!out_valid && !in_ready));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  a_r11_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  a_r12_map_locked: assert property (@(posedge clk) disable iff (!rst_n)
    map_ready |=> $stable(fault_flat));

endmodule

bind spare_remap spare_remap_chk #(
  .GROUPS(GROUPS), .GP(GP), .NPHYS(NPHYS), .PW(PW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_done  (cfg_done),
  .map_ready (map_ready),
  .yielded   (yielded),
  .bad_groups(bad_groups),
  .fault_flat(fault_flat),
  .look_valid(look_valid),
  .look_phys (look_phys),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready)
);

// File: tb/sim_spare_remap.sv
`timescale 1ns/1ps
module sim_spare_remap;
  localparam int GROUPS = 4, LPG = 4, SPARES = 2, W = 8;
  localparam int GP = LPG + SPARES, NLOG = GROUPS*LPG, NPHYS = GROUPS*GP;
  localparam int LW = $clog2(NLOG), PW = $clog2(NPHYS), GSEL_W = $clog2(GROUPS);

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_we = 0, cfg_done = 0;
  logic [GSEL_W-1:0] cfg_grp = '0;
  logic [GP-1:0] cfg_mask = '0;
  logic map_ready, yielded, look_valid, in_ready, out_valid;
  logic [GROUPS-1:0] bad_groups;
  logic [LW-1:0] look_idx = '0;
  logic [PW-1:0] look_phys;
  logic in_valid = 0, out_ready = 0;
  logic [NPHYS*W-1:0] in_data = '0;
  logic [NLOG*W-1:0] out_data;

  int compared = 0, mismatched = 0;
  string force_tag = "";

  always #2 clk = ~clk;

  spare_remap u0 (.*);

  // reference model
  logic [GP-1:0] m_mask [GROUPS];
  bit m_flag [GROUPS];
  bit m_ready;
  initial begin
    for (int g = 0; g < GROUPS; g++) begin m_mask[g] = '0; m_flag[g] = 0; end
    m_ready = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUPS; g++) begin m_mask[g] = '0; m_flag[g] = 0; end
      m_ready = 0;
    end else begin
      if (cfg_en && cfg_we && !m_ready && int'(cfg_grp) < GROUPS) begin
        int n;
        n = 0;
        m_mask[cfg_grp] = cfg_mask;
        for (int p = 0; p < GP; p++) if (cfg_mask[p]) n++;
        if (n > SPARES) m_flag[cfg_grp] = 1;
      end
      if (cfg_done) m_ready = 1;
    end
  end

  function automatic int ref_phys(int idx);
    int g, k, good;
    g = idx / LPG; k = idx % LPG; good = -1;
    for (int p = 0; p < GP; p++) begin
      if (!m_mask[g][p]) begin
        good++;
        if (good == k) return g*GP + p;
      end
    end
    return g*GP + k;
  endfunction

  function automatic string grp_tag(int g);
    if (force_tag != "") return force_tag;
    case (g)
      0: return "R2";
      1: return "R5";
      2: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit fl_any;
    logic [GROUPS-1:0] ef;
    logic [NLOG*W-1:0] ed;
    int g;
    fl_any = 0;
    for (int i = 0; i < GROUPS; i++) begin ef[i] = m_flag[i]; fl_any |= m_flag[i]; end
    chk("R3", "map_ready", 256'(map_ready), 256'(m_ready));
    chk("R8", "yielded", 256'(yielded), 256'(m_ready && !fl_any));
    chk("R7", "bad_groups", 256'(bad_groups), 256'(ef));
    g = int'(look_idx) / LPG;
    chk("R9", "look_valid", 256'(look_valid), 256'(m_ready && !m_flag[g]));
    if (m_ready && !m_flag[g])
      chk(grp_tag(g), "look_phys", 256'(look_phys), 256'(ref_phys(int'(look_idx))));
    chk("R11", "out_valid", 256'(out_valid), 256'(in_valid && m_ready));
    chk("R11", "in_ready", 256'(in_ready), 256'(out_ready && m_ready));
    if (in_valid && m_ready) begin
      for (int l = 0; l < NLOG; l++) ed[l*W +: W] = in_data[ref_phys(l)*W +: W];
      chk("R10", "out_data", 256'(out_data), 256'(ed));
    end
  endtask

  task automatic tick();
    #1 compare_all();
    @(negedge clk);
  endtask

  task automatic wr(bit en, int g, logic [GP-1:0] m);
    cfg_en = en; cfg_we = 1; cfg_grp = GSEL_W'(g); cfg_mask = m;
    tick();
    cfg_en = 0; cfg_we = 0;
  endtask

  task automatic rand_beat();
    for (int p = 0; p < NPHYS; p++) in_data[p*W +: W] = W'($urandom);
    in_valid = 1'($urandom); out_ready = 1'($urandom);
  endtask

  task automatic sweep();
    for (int i = 0; i < NLOG; i++) begin
      look_idx = LW'(i); rand_beat(); tick();
    end
    in_valid = 1; tick();
  endtask

  initial begin
    @(negedge clk);
    #1;
    chk("R1", "map_ready", 256'(map_ready), 0);
    chk("R1", "yielded", 256'(yielded), 0);
    chk("R1", "bad_groups", 256'(bad_groups), 0);
    chk("R1", "out_valid", 256'(out_valid), 0);
    chk("R1", "in_ready", 256'(in_ready), 0);
    @(negedge clk); rst_n = 1; in_valid = 1; out_ready = 1;
    tick();
    // session 1
    wr(0, 0, 6'b000101);        // R2: ignored, cfg_en low
    wr(1, 1, 6'b000100);        // R5: single fault at 2
    wr(1, 2, 6'b001001);        // R6: two faults at 0 and 3
    wr(1, 3, 6'b000000);        // R4: clean
    sweep();                    // R9: not valid before done
    cfg_done = 1; tick(); cfg_done = 0;
    force_tag = "R12";
    wr(1, 1, 6'b000001);        // ignored after freeze
    for (int i = LPG; i < 2*LPG; i++) begin look_idx = LW'(i); tick(); end
    force_tag = "";
    sweep(); sweep();
    // session 2: unrepairable group
    @(negedge clk); rst_n = 0; tick(); rst_n = 1; tick();
    wr(1, 3, 6'b000111);        // R7: three faults > two spares
    wr(1, 3, 6'b000000);        // flag must persist
    wr(1, 0, 6'b100000);        // spare faulty: identity
    cfg_done = 1; tick(); cfg_done = 0;
    force_tag = "R7";
    sweep();
    force_tag = "";
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule